// File: doc/BRIEF.md
# Associative Translation Lookaside Buffer with Capability Flags

This block translates a 64-bit virtual address into a physical address by searching a small, fully associative table of page-pair entries. Each entry describes two adjacent pages, one even and one odd, that share a tag made of a region field, a virtual page-pair number, an address-space identifier and a page-size mask. A request supplies the virtual address, whether the access is a store, and the current address-space identifier. One cycle later the block returns the physical address and a capability permission flag, or an exception code when the lookup fails.

Every page holds two capability permission bits, one that governs stores and one that governs loads. The bit that matches the access type is returned with the translated address. Entries are loaded through a single write port, one whole entry per clock, from the surrounding register logic. The search and the page selection are combinational. The response is captured in registers on a one-cycle valid handshake.

Top module: `tlb_xlate_unit`

## Requirements
- R1: With `wr_en` high at a clock edge, `wr_data` replaces entry `wr_idx`. A lookup requested in the same cycle still sees the previous contents, and a lookup in a later cycle sees the new ones. Reset clears every entry, so no entry matches. Entry layout in `wr_data`: live[116], global[115], asid[114:107], region[106:105], vpn2[104:78], mask[77:62], even page[61:31], odd page[30:0]. Page layout within its 31 bits: valid[30], dirty[29], cache attribute[28:26], pfn[25:2], load-capability[1], store-capability[0].
- R2: An entry matches only when all four of these hold. Its live bit is set. Its region equals address bits [63:62]. Its vpn2 equals address bits [39:13] at every position where the zero-extended mask bit is clear. Its global bit is set or its asid equals `cur_asid`.
- R3: The page-select bit is address bit 12 when the mask is 0x0000. Each further pair of set low mask bits raises it by two: 0x0003 gives bit 14, 0x000F gives bit 16, and so on up to 0xFFFF, which gives bit 28. The odd page is used when the select bit is 1. Only these nine mask values are defined.
- R4: For a select bit s, the physical address is pfn bits [23:s-12] placed at bit s and above, with virtual address bits [s-1:0] below them, zero-extended to 64 bits.
- R5: When several entries match, the one with the lowest index is used.
- R6: When no entry matches, the block reports refill: code 0 for a load, code 1 for a store.
- R7: When the selected page's valid bit is clear, the block reports invalid: code 2 for a load, code 3 for a store.
- R8: A store to a valid page whose dirty bit is clear reports code 4 (modified). A load from such a page translates normally.
- R9: On a successful translation `rsp_cap` is the page's store-capability bit for a store and its load-capability bit for a load.
- R10: When the translated address has any bit set at or above position `PA_LIMIT_BITS`, the block reports an address error: code 5 for a load, code 6 for a store.
- R11: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. On an exception `rsp_exc` is 1, `rsp_paddr` is 0 and `rsp_cap` is 0. When several exceptions apply, the priority is refill, then invalid, then modified, then address error.
- R12: After reset `rsp_valid` and `rsp_exc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_data | input | 117 | Entry contents (layout in R1) |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 64 | Virtual address |
| req_store | input | 1 | 1 for a store, 0 for a load |
| cur_asid | input | 8 | Current address-space identifier |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_paddr | output | 64 | Physical address (0 on exception) |
| rsp_cap | output | 1 | Capability permission for this access |
| rsp_exc | output | 1 | Translation failed |
| rsp_exc_code | output | 3 | Exception code (R6, R7, R8, R10) |

## Verification
The nine legal masks are swept one at a time. For each one the address bits under the mask are flipped, which shows that masked bits are ignored, and the first tag bit above the mask is flipped, which must turn the lookup into a refill. The select bit is driven both ways to separate the even page from the odd page. Single-field mismatches in asid, region and vpn2, with the global bit set and clear, show that each match term is needed. Overlapping entries, entries with invalid, clean and out-of-range pages, and a write issued in the same cycle as a lookup separate the priority orders and the read-before-write timing.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W       = 64;
  localparam int PFN_W      = 24;
  localparam int VPN2_W     = 27;
  localparam int ASID_W     = 8;
  localparam int MASK_W     = 16;
  localparam int REGION_W   = 2;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN2_LSB   = PAGE_SHIFT + 1;
  localparam int CODE_W     = 3;

  typedef struct packed {
    logic              valid;
    logic              dirty;
    logic [2:0]        cache;
    logic [PFN_W-1:0]  pfn;
    logic              cap_ld;
    logic              cap_st;
  } page_t;

  typedef struct packed {
    logic                live;
    logic                global;
    logic [ASID_W-1:0]   asid;
    logic [REGION_W-1:0] region;
    logic [VPN2_W-1:0]   vpn2;
    logic [MASK_W-1:0]   mask;
    page_t               even;
    page_t               odd;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  typedef enum logic [CODE_W-1:0] {
    EXC_REFILL_LD = 3'd0,
    EXC_REFILL_ST = 3'd1,
    EXC_INV_LD    = 3'd2,
    EXC_INV_ST    = 3'd3,
    EXC_MOD       = 3'd4,
    EXC_ADDR_LD   = 3'd5,
    EXC_ADDR_ST   = 3'd6
  } exc_code_e;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  entry_t              wr_data,
  input  logic [VA_W-1:0]     look_va,
  input  logic [ASID_W-1:0]   look_asid,
  output entry_t              ents [N_ENTRIES],
  output logic [N_ENTRIES-1:0] hit
);
  localparam int REGION_LSB = VA_W - REGION_W;

  logic unused_va_bits;
  assign unused_va_bits = ^{look_va[REGION_LSB-1:VPN2_LSB+VPN2_W], look_va[VPN2_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENTRIES; i++) ents[i] <= '0;
    end else if (wr_en) begin
      ents[wr_idx] <= wr_data;
    end
  end

  logic [VPN2_W-1:0]   va_vpn2;
  logic [REGION_W-1:0] va_region;
  assign va_vpn2   = look_va[VPN2_LSB +: VPN2_W];
  assign va_region = look_va[REGION_LSB +: REGION_W];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic [VPN2_W-1:0] care;
    logic tag_eq, asid_ok;
    assign care    = ~{{(VPN2_W-MASK_W){1'b0}}, ents[g].mask};
    assign tag_eq  = ((va_vpn2 ^ ents[g].vpn2) & care) == '0;
    assign asid_ok = ents[g].global || (ents[g].asid == look_asid);
    assign hit[g]  = ents[g].live && (ents[g].region == va_region) && tag_eq && asid_ok;
  end

  // R1: a write is visible in the store on the following cycle
  p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ents[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int N_ENTRIES = 8,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_ENTRIES-1:0] hit,
  output logic                 any,
  output logic [IDX_W-1:0]     idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  // R5: the chosen entry really hits and no lower entry does
  p_pick_hits_r5: assert property (@(posedge clk) disable iff (rst)
    any |-> hit[idx]);
  p_pick_lowest_r5: assert property (@(posedge clk) disable iff (rst)
    any |-> (hit & ((N_ENTRIES'(1) << idx) - N_ENTRIES'(1))) == '0);
endmodule

// File: rtl/tlb_page_xlate.sv
module tlb_page_xlate
  import tlb_pkg::*;
#(
  parameter int PA_LIMIT_BITS = 36
) (
  input  entry_t            ent,
  input  logic              hit_any,
  input  logic [VA_W-1:0]   va,
  input  logic              is_store,
  output logic [VA_W-1:0]   pa,
  output logic              cap,
  output logic              exc,
  output exc_code_e         code
);
  localparam int PAIRS   = MASK_W / 2;
  localparam int PAIR_W  = $clog2(PAIRS + 1);
  localparam int SEL_W   = $clog2(PAGE_SHIFT + MASK_W + 1);

  logic [PAIR_W-1:0] pairs;
  logic [SEL_W-1:0]  sel;
  logic              odd;
  page_t             pg;
  logic [VA_W-1:0]   low_mask, base, pa_raw;
  logic              over;
  logic              unused_attr;

  always_comb begin
    pairs = '0;
    for (int k = 0; k < PAIRS; k++) pairs = pairs + PAIR_W'(ent.mask[2*k]);
  end

  assign sel      = SEL_W'(PAGE_SHIFT) + SEL_W'({pairs, 1'b0});
  assign odd      = va[sel];
  assign pg       = odd ? ent.odd : ent.even;
  assign unused_attr = ^pg.cache;
  assign low_mask = (VA_W'(1) << sel) - VA_W'(1);
  assign base     = VA_W'(pg.pfn) << PAGE_SHIFT;
  assign pa_raw   = (base & ~low_mask) | (va & low_mask);
  assign over     = (pa_raw >> PA_LIMIT_BITS) != '0;

  always_comb begin
    exc  = 1'b1;
    pa   = '0;
    cap  = 1'b0;
    code = is_store ? EXC_REFILL_ST : EXC_REFILL_LD;
    if (!hit_any) begin
      code = is_store ? EXC_REFILL_ST : EXC_REFILL_LD;
    end else if (!pg.valid) begin
      code = is_store ? EXC_INV_ST : EXC_INV_LD;
    end else if (is_store && !pg.dirty) begin
      code = EXC_MOD;
    end else if (over) begin
      code = is_store ? EXC_ADDR_ST : EXC_ADDR_LD;
    end else begin
      exc  = 1'b0;
      pa   = pa_raw;
      cap  = is_store ? pg.cap_st : pg.cap_ld;
    end
  end
endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES     = 8,
  parameter int PA_LIMIT_BITS = 36,
  parameter int IDX_W         = $clog2(N_ENTRIES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [ENTRY_W-1:0]  wr_data,
  input  logic                req_valid,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic                req_store,
  input  logic [ASID_W-1:0]   cur_asid,
  output logic                rsp_valid,
  output logic [VA_W-1:0]     rsp_paddr,
  output logic                rsp_cap,
  output logic                rsp_exc,
  output logic [CODE_W-1:0]   rsp_exc_code
);
  entry_t                ents [N_ENTRIES];
  logic [N_ENTRIES-1:0]  hit;
  logic                  hit_any;
  logic [IDX_W-1:0]      hit_idx;
  logic [VA_W-1:0]       x_pa;
  logic                  x_cap, x_exc;
  exc_code_e             x_code;

  tlb_entry_store #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(entry_t'(wr_data)), .look_va(req_vaddr), .look_asid(cur_asid),
    .ents(ents), .hit(hit)
  );

  tlb_first_hit #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst(rst), .hit(hit), .any(hit_any), .idx(hit_idx)
  );

  tlb_page_xlate #(.PA_LIMIT_BITS(PA_LIMIT_BITS)) u_xlate (
    .ent(ents[hit_idx]), .hit_any(hit_any), .va(req_vaddr), .is_store(req_store),
    .pa(x_pa), .cap(x_cap), .exc(x_exc), .code(x_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_cap      <= 1'b0;
      rsp_exc      <= 1'b0;
      rsp_exc_code <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr    <= x_pa;
        rsp_cap      <= x_cap;
        rsp_exc      <= x_exc;
        rsp_exc_code <= x_code;
      end
    end
  end

  // R11: response follows request by exactly one cycle
  p_rsp_timing_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_rsp_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R11: a failed translation carries no address and no permission
  p_exc_clean_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc) |-> (rsp_paddr == '0 && !rsp_cap));
  // R10: a successful address never exceeds the physical limit
  p_pa_limit_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_exc) |-> (rsp_paddr >> PA_LIMIT_BITS) == '0);
  // R4: page offset passes through unchanged
  p_offset_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_exc) |-> rsp_paddr[PAGE_SHIFT-1:0] == $past(req_vaddr[PAGE_SHIFT-1:0]));
  // R8: the modified exception only comes from stores
  p_mod_store_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_exc && rsp_exc_code == EXC_MOD) |-> $past(req_store));
endmodule

// File: tb/tlb_xlate_unit_tb.sv
module tlb_xlate_unit_tb;
  localparam int N   = 8;
  localparam int PAL = 34;

  logic clk = 0, rst = 1;
  logic wr_en = 0;
  logic [2:0] wr_idx = '0;
  logic [116:0] wr_data = '0;
  logic req_valid = 0, req_store = 0;
  logic [63:0] req_vaddr = '0;
  logic [7:0] cur_asid = '0;
  logic rsp_valid, rsp_cap, rsp_exc;
  logic [63:0] rsp_paddr;
  logic [2:0] rsp_exc_code;

  int checks = 0, failures = 0;
  logic [116:0] mdl [N];

  always #10 clk = ~clk;

  tlb_xlate_unit #(.N_ENTRIES(N), .PA_LIMIT_BITS(PAL)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_store(req_store),
    .cur_asid(cur_asid), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_cap(rsp_cap), .rsp_exc(rsp_exc), .rsp_exc_code(rsp_exc_code)
  );

  function automatic [30:0] pg(input v, input d, input [23:0] pfn, input capl, input caps);
    return {v, d, 3'b101, pfn, capl, caps};
  endfunction

  function automatic [116:0] ent(input live, input g, input [7:0] asid, input [1:0] rg,
                                 input [26:0] vpn, input [15:0] msk,
                                 input [30:0] ev, input [30:0] od);
    return {live, g, asid, rg, vpn, msk, ev, od};
  endfunction

  function automatic [63:0] mkva(input [1:0] rg, input [26:0] vpn, input [12:0] off);
    return {rg, 22'b0, vpn, off};
  endfunction

  // Reference: computed from R2..R11
  task automatic model(input [63:0] va, input st, input [7:0] asid,
                       output [63:0] pa, output cap, output exc, output [2:0] code);
    int found = -1;
    logic [116:0] e;
    logic [30:0] p;
    int s;
    logic [63:0] raw;
    pa = 0; cap = 0; exc = 1; code = st ? 3'd1 : 3'd0;
    for (int i = N - 1; i >= 0; i--) begin
      e = mdl[i];
      if (e[116] && e[106:105] == va[63:62] &&
          (((e[104:78] ^ va[39:13]) & ~{11'b0, e[77:62]}) == 0) &&
          (e[115] || e[114:107] == asid))
        found = i;
    end
    if (found < 0) return;
    e = mdl[found];
    s = 12 + $countones(e[77:62]);
    p = va[s] ? e[30:0] : e[61:31];
    raw = ((64'(p[25:2]) >> (s - 12)) << s) | (va & ((64'd1 << s) - 1));
    if (!p[30]) code = st ? 3'd3 : 3'd2;
    else if (st && !p[29]) code = 3'd4;
    else if (raw >= (64'd1 << PAL)) code = st ? 3'd6 : 3'd5;
    else begin exc = 0; pa = raw; cap = st ? p[0] : p[1]; code = 0; end
  endtask

  task automatic wr(input int idx, input [116:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = 3'(idx); wr_data = d;
    @(posedge clk); #1;
    wr_en = 0; mdl[idx] = d;
  endtask

  task automatic compare(input string tag, input [63:0] epa, input ecap, input eexc, input [2:0] ecode);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_exc !== eexc || rsp_paddr !== epa || rsp_cap !== ecap ||
        (eexc && rsp_exc_code !== ecode)) begin
      failures++;
      $display("FAIL %s: got v=%0b exc=%0b code=%0d pa=%h cap=%0b, expected v=1 exc=%0b code=%0d pa=%h cap=%0b",
               tag, rsp_valid, rsp_exc, rsp_exc_code, rsp_paddr, rsp_cap, eexc, ecode, epa, ecap);
    end
  endtask

  task automatic look(input [63:0] va, input st, input [7:0] asid, input string tag);
    logic [63:0] epa; logic ecap, eexc; logic [2:0] ecode;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_store = st; cur_asid = asid;
    model(va, st, asid, epa, ecap, eexc, ecode);
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    compare(tag, epa, ecap, eexc, ecode);
  endtask

  task automatic expect_code(input [2:0] c, input string tag);
    checks++;
    if (rsp_exc !== 1'b1 || rsp_exc_code !== c) begin
      failures++;
      $display("FAIL %s: got exc=%0b code=%0d, expected exc=1 code=%0d", tag, rsp_exc, rsp_exc_code, c);
    end
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] va;
    logic [26:0] vb;
    for (int i = 0; i < N; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R12: reset state
    checks++;
    if (rsp_valid !== 0 || rsp_exc !== 0) begin
      failures++;
      $display("FAIL R12: got v=%0b exc=%0b, expected 0 0", rsp_valid, rsp_exc);
    end

    // R1, R6: empty table refills
    look(mkva(2'd0, 27'h0, 13'h0), 0, 8'd0, "R1 empty load");
    look(mkva(2'd0, 27'h0, 13'h0), 0, 8'd0, "R6 refill load");
    expect_code(3'd0, "R6 code load");
    look(mkva(2'd1, 27'h123, 13'h55), 1, 8'd3, "R6 refill store");
    expect_code(3'd1, "R6 code store");
    // R11: no request, no response
    @(negedge clk);
    checks++;
    if (rsp_valid !== 0) begin
      failures++;
      $display("FAIL R11 idle: got v=%0b, expected 0", rsp_valid);
    end

    // R2, R4, R9, R8, R3 with a 4K entry
    wr(3, ent(1, 0, 8'd5, 2'd1, 27'h2ABCDEF, 16'h0,
              pg(1, 1, 24'h012345, 0, 1), pg(1, 0, 24'h0ABCDE, 1, 0)));
    look(mkva(2'd1, 27'h2ABCDEF, 13'h0ABC), 0, 8'd5, "R4 even load");
    look(mkva(2'd1, 27'h2ABCDEF, 13'h0ABC), 1, 8'd5, "R9 even store cap");
    look(mkva(2'd1, 27'h2ABCDEF, 13'h1FFF), 0, 8'd5, "R3 odd load");
    look(mkva(2'd1, 27'h2ABCDEF, 13'h1001), 1, 8'd5, "R8 odd clean store");
    expect_code(3'd4, "R8 modified code");
    look(mkva(2'd1, 27'h2ABCDEF, 13'h0ABC), 0, 8'd6, "R2 asid mismatch");
    look(mkva(2'd2, 27'h2ABCDEF, 13'h0ABC), 0, 8'd5, "R2 region mismatch");
    look(mkva(2'd1, 27'h2ABCDEE, 13'h0ABC), 0, 8'd5, "R2 vpn2 mismatch");
    look(mkva(2'd1, 27'h6ABCDEF, 13'h0ABC), 0, 8'd5, "R2 vpn2 top bit");
    // global entry
    wr(5, ent(1, 1, 8'd9, 2'd0, 27'h0000777, 16'h0,
              pg(1, 1, 24'h000100, 1, 1), pg(1, 1, 24'h000200, 0, 0)));
    look(mkva(2'd0, 27'h0000777, 13'h1234), 0, 8'd77, "R2 global any asid");
    look(mkva(2'd0, 27'h0000777, 13'h0234), 1, 8'd0, "R2 global store");

    // R7, R11 priority: invalid before modified
    wr(4, ent(1, 0, 8'd2, 2'd2, 27'h0000042, 16'h0,
              pg(0, 0, 24'h000010, 1, 1), pg(1, 1, 24'h000020, 1, 1)));
    look(mkva(2'd2, 27'h0000042, 13'h0010), 0, 8'd2, "R7 invalid load");
    expect_code(3'd2, "R7 code load");
    look(mkva(2'd2, 27'h0000042, 13'h0010), 1, 8'd2, "R7 invalid store");
    expect_code(3'd3, "R11 invalid over modified");

    // R10 and priority modified over address error
    wr(6, ent(1, 0, 8'd1, 2'd0, 27'h0001000, 16'h0,
              pg(1, 1, 24'h400001, 1, 1), pg(1, 0, 24'hC00000, 1, 1)));
    look(mkva(2'd0, 27'h0001000, 13'h0008), 0, 8'd1, "R10 addr error load");
    expect_code(3'd5, "R10 code load");
    look(mkva(2'd0, 27'h0001000, 13'h0008), 1, 8'd1, "R10 addr error store");
    expect_code(3'd6, "R10 code store");
    look(mkva(2'd0, 27'h0001000, 13'h1008), 1, 8'd1, "R11 modified over addr");
    expect_code(3'd4, "R11 modified code");

    // R5: overlapping entries, lowest index wins
    wr(2, ent(1, 0, 8'd1, 2'd0, 27'h0001000, 16'h0,
              pg(1, 1, 24'h000AAA, 0, 1), pg(1, 1, 24'h000BBB, 1, 0)));
    look(mkva(2'd0, 27'h0001000, 13'h0008), 0, 8'd1, "R5 lowest wins");
    // R1: same-cycle write sees old content, next lookup sees new
    begin
      logic [63:0] epa; logic ecap, eexc; logic [2:0] ecode;
      va = mkva(2'd0, 27'h0001000, 13'h0010);
      @(negedge clk);
      wr_en = 1; wr_idx = 3'd2; wr_data = '0;
      req_valid = 1; req_vaddr = va; req_store = 0; cur_asid = 8'd1;
      model(va, 0, 8'd1, epa, ecap, eexc, ecode);
      @(posedge clk); #1;
      wr_en = 0; req_valid = 0; mdl[2] = '0;
      @(negedge clk);
      compare("R1 write same cycle old", epa, ecap, eexc, ecode);
    end
    look(mkva(2'd0, 27'h0001000, 13'h0010), 0, 8'd1, "R1 write visible next");

    // R3, R4, R2: mask sweep on a dedicated region
    for (int k = 0; k <= 8; k++) begin
      logic [15:0] m;
      int s;
      m  = 16'((32'd1 << (2 * k)) - 1);
      s  = 12 + 2 * k;
      vb = 27'h5A5A5A5;
      wr(1, ent(1, 0, 8'd7, 2'd3, vb, m,
                pg(1, 1, 24'h2BCDE1, 0, 1), pg(1, 1, 24'h13579B, 1, 0)));
      for (int sb = 0; sb < 2; sb++) begin
        for (int fl = 0; fl < 2; fl++) begin
          logic [26:0] v2;
          v2 = fl ? (vb ^ {11'b0, m}) : vb;
          va = mkva(2'd3, v2, 13'h1A5A);
          va[s] = sb[0];
          look(va, fl[0], 8'd7, "R3 R4 mask sweep");
        end
      end
      va = mkva(2'd3, vb ^ (27'd1 << (2 * k)), 13'h0);
      look(va, 0, 8'd7, "R2 bit above mask");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule